// File: doc/BRIEF.md
# Buffered-Compare PWM Down Counter

This block is an 8-bit pulse-width modulator built around a synchronous down counter. Software sets up a period, a compare value, an enable bit and a compare-mode bit through a small register bus. The counter runs from the period value down to zero and then reloads. The primary output is high while the count stands below the compare value, or at or below it, depending on the mode bit. An auxiliary output marks the zero count, and a terminal-count pulse flags each entry into zero.

While the counter runs, new period and compare values do not disturb the cycle in progress. The period register feeds the counter only at reload. A compare write waits in a holding register and moves into the active compare register at that same reload. While the block is disabled, the counter stays put. A period write then presets the count directly. A read of the count address returns zero and copies the live count into the compare register, so that software can read it back from there.

Top module: `pwm_buffered`

## Requirements
- R1: After reset, the count, period and compare registers are zero and the block is disabled. pwm_out, aux_out and tc_pulse are low, and reads of the compare (addr 2) and control (addr 3) addresses return 0.
- R2: While disabled, a write to the period address (addr 1) loads the written value into the count on the same clock edge.
- R3: While enabled, a nonzero count decrements by one each clock. A zero count reloads the period value on the next clock, so one cycle lasts period + 1 clocks.
- R4: aux_out is high exactly when the block is enabled and the count is zero. A period of 0 therefore keeps aux_out continuously high.
- R5: tc_pulse is high for one clock when aux_out goes from low to high. It is never high on two consecutive clocks.
- R6: pwm_out is high while enabled and the count is below the active compare value when control bit 1 is 0, or at or below it when control bit 1 is 1. It is low while disabled.
- R7: While enabled, a compare write is held. It becomes the active compare value on the first reload edge after the write edge, and reads of addr 2 return the active value.
- R8: While enabled, a period write does not disturb the current count. The new period is first used at the first reload after the write edge.
- R9: While disabled, a read of the count address (addr 0) returns 0 and copies the count into the active and holding compare registers.
- R10: While enabled, a read of addr 0 returns 0 and leaves the compare registers unchanged.
- R11: While disabled, a compare write takes effect at once. Control bit 0 is the enable and bit 1 the mode, and both read back at addr 3.
- R12: While disabled and without a period write, the count holds its value.
- R13: Reads of the write-only period address (addr 1) return 0. Read data appears one clock after rd_en and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 count, 1 period, 2 compare, 3 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pwm_out | output | 1 | Primary compare output |
| aux_out | output | 1 | High while enabled at zero count |
| tc_pulse | output | 1 | One-clock terminal-count pulse |

## Verification
The assertions assume that the bus inputs are driven to known values from time zero. They also assume that a count read and a compare write never fall on the same edge, because the capture property excludes that overlap. The bench issues at most one bus access at a time from tasks that drive on falling edges, and the only way it changes the enable is through the control address. The sweep over every period from 0 to 9, every compare value from 0 to 11 and both modes therefore covers each compare boundary without ever producing a conflicting access.

// File: rtl/pwm_buffered_pkg.sv
package pwm_buffered_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_CNT = 2'd0,
        A_PER = 2'd1,
        A_CMP = 2'd2,
        A_CTL = 2'd3
    } reg_addr_e;

    typedef enum logic {
        CMP_LT = 1'b0,
        CMP_LE = 1'b1
    } cmp_mode_e;

    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_MODE_BIT = 1;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_buffered_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [WIDTH-1:0]  count_i,
    input  logic              reload_i,
    output logic [WIDTH-1:0]  rdata_o,
    output logic [WIDTH-1:0]  period_o,
    output logic [WIDTH-1:0]  cmp_o,
    output logic              en_o,
    output logic              mode_o,
    output logic              per_load_o
);
    localparam int PAD_W = WIDTH - 2;

    typedef struct packed {
        logic [WIDTH-1:0] period;
        logic [WIDTH-1:0] cmp_act;
        logic [WIDTH-1:0] cmp_buf;
        logic [WIDTH-1:0] rdata;
        logic             en;
        logic             mode;
    } regs_t;

    regs_t s_d, s_q;
    logic  hit_cnt, hit_per, hit_cmp, hit_ctl;

    always_comb begin
        hit_cnt = (addr == A_CNT);
        hit_per = (addr == A_PER);
        hit_cmp = (addr == A_CMP);
        hit_ctl = (addr == A_CTL);
        s_d     = s_q;

        if (wr_en && hit_per) s_d.period = wdata;
        if (wr_en && hit_ctl) begin
            s_d.en   = wdata[CTL_EN_BIT];
            s_d.mode = wdata[CTL_MODE_BIT];
        end

        if (rd_en) begin
            unique case (1'b1)
                hit_cmp: s_d.rdata = s_q.cmp_act;
                hit_ctl: s_d.rdata = {{PAD_W{1'b0}}, s_q.mode, s_q.en};
                default: s_d.rdata = '0;
            endcase
        end

        // disabled capture of the live count
        if (rd_en && hit_cnt && !s_q.en) begin
            s_d.cmp_act = count_i;
            s_d.cmp_buf = count_i;
        end

        // reload moves the held value that existed before this edge
        if (reload_i) s_d.cmp_act = s_q.cmp_buf;

        if (wr_en && hit_cmp) begin
            s_d.cmp_buf = wdata;
            if (!s_q.en) s_d.cmp_act = wdata;
        end

        per_load_o = wr_en && hit_per && !s_q.en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata_o  = s_q.rdata;
    assign period_o = s_q.period;
    assign cmp_o    = s_q.cmp_act;
    assign en_o     = s_q.en;
    assign mode_o   = s_q.mode;
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [WIDTH-1:0] period_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_val_i,
    output logic [WIDTH-1:0] count_o,
    output logic             reload_o,
    output logic             aux_o,
    output logic             tc_pulse_o
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] count;
        logic             aux_prev;
    } cnt_t;

    cnt_t s_d, s_q;
    logic at_zero;

    always_comb begin
        s_d        = s_q;
        at_zero    = (s_q.count == '0);
        aux_o      = en_i && at_zero;
        reload_o   = aux_o;
        tc_pulse_o = aux_o && !s_q.aux_prev;

        if (load_i)    s_d.count = load_val_i;
        else if (en_i) s_d.count = at_zero ? period_i : (s_q.count - ONE);

        s_d.aux_prev = aux_o;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count_o = s_q.count;
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
    import pwm_buffered_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             en_i,
    input  logic             mode_i,
    input  logic [WIDTH-1:0] count_i,
    input  logic [WIDTH-1:0] cmp_i,
    output logic             pwm_o
);
    logic below, equal;

    always_comb begin
        below = (count_i < cmp_i);
        equal = (count_i == cmp_i);
        unique case (cmp_mode_e'(mode_i))
            CMP_LE:  pwm_o = en_i && (below || equal);
            default: pwm_o = en_i && below;
        endcase
    end
endmodule

// File: rtl/pwm_buffered.sv
module pwm_buffered
    import pwm_buffered_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  rdata,
    output logic              pwm_out,
    output logic              aux_out,
    output logic              tc_pulse
);
    logic [WIDTH-1:0] count_w, period_w, cmp_w;
    logic             en_w, mode_w, per_load_w, reload_w;

    pwm_regs #(.WIDTH(WIDTH)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .count_i    (count_w),
        .reload_i   (reload_w),
        .rdata_o    (rdata),
        .period_o   (period_w),
        .cmp_o      (cmp_w),
        .en_o       (en_w),
        .mode_o     (mode_w),
        .per_load_o (per_load_w)
    );

    pwm_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_w),
        .period_i   (period_w),
        .load_i     (per_load_w),
        .load_val_i (wdata),
        .count_o    (count_w),
        .reload_o   (reload_w),
        .aux_o      (aux_out),
        .tc_pulse_o (tc_pulse)
    );

    pwm_compare #(.WIDTH(WIDTH)) u_cmp (
        .en_i    (en_w),
        .mode_i  (mode_w),
        .count_i (count_w),
        .cmp_i   (cmp_w),
        .pwm_o   (pwm_out)
    );
endmodule

// File: rtl/pwm_buffered_chk.sv
module pwm_buffered_chk
    import pwm_buffered_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [WIDTH-1:0]  wdata,
    input logic [WIDTH-1:0]  rdata,
    input logic [WIDTH-1:0]  count,
    input logic [WIDTH-1:0]  period,
    input logic [WIDTH-1:0]  cmp_act,
    input logic              en,
    input logic              pwm_out,
    input logic              aux_out,
    input logic              tc_pulse
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    p_preset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && addr == A_PER && !en) |-> count == $past(wdata));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en && count != '0) |-> count == $past(count) - ONE);

    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en && count == '0) |-> count == $past(period));

    p_flat_aux_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en && period == '0 && count == '0)) |-> aux_out);

    p_tc_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |=> !tc_pulse);

    p_cmp_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en && count != '0) |-> cmp_act == $past(cmp_act));

    p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && addr == A_CNT && !en && !(wr_en && addr == A_CMP))
        |-> (rdata == '0 && cmp_act == $past(count)));

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!en && !(wr_en && addr == A_PER)) |-> $stable(count));

    p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!pwm_out && !aux_out && !tc_pulse));
endmodule

bind pwm_buffered pwm_buffered_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .count    (count_w),
    .period   (period_w),
    .cmp_act  (cmp_w),
    .en       (en_w),
    .pwm_out  (pwm_out),
    .aux_out  (aux_out),
    .tc_pulse (tc_pulse)
);

// File: tb/pwm_buffered_test.sv
`timescale 1ns/1ps
module pwm_buffered_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       pwm_out, aux_out, tc_pulse;
    int         checks = 0;
    int         errors = 0;
    logic [7:0] rv;

    localparam logic [1:0] AD_CNT = 2'd0, AD_PER = 2'd1, AD_CMP = 2'd2, AD_CTL = 2'd3;

    always #2.5 clk = ~clk;

    pwm_buffered uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out), .aux_out(aux_out),
        .tc_pulse(tc_pulse)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pwm", int'(pwm_out), 0);
        chk("R1 aux", int'(aux_out), 0);
        chk("R1 tc", int'(tc_pulse), 0);
        rd(AD_CMP, rv); chk("R1 cmp", int'(rv), 0);
        rd(AD_CTL, rv); chk("R1 ctl", int'(rv), 0);

        // R13 period read, R2 disabled preset seen through capture
        wr(AD_PER, 8'h5A);
        rd(AD_PER, rv); chk("R13 period reads zero", int'(rv), 0);
        rd(AD_CNT, rv); chk("R9 count reads zero", int'(rv), 0);
        rd(AD_CMP, rv); chk("R2 preset count", int'(rv), 8'h5A);

        // R11 disabled compare write and control readback
        wr(AD_CMP, 8'h33);
        rd(AD_CMP, rv); chk("R11 cmp immediate", int'(rv), 8'h33);
        wr(AD_CTL, 8'h02);
        rd(AD_CTL, rv); chk("R11 ctl readback", int'(rv), 2);

        // R3 R4 R5 R6 sweep
        for (int p = 0; p <= 9; p++) begin
            for (int c = 0; c <= 11; c++) begin
                for (int m = 0; m <= 1; m++) begin
                    int hi, lim;
                    hi = 0;
                    wr(AD_CTL, 8'h00);
                    wr(AD_PER, 8'(p));
                    wr(AD_CMP, 8'(c));
                    wr(AD_CTL, 8'(m * 2 + 1));
                    for (int k = 0; k <= p; k++) begin
                        int cnt;
                        cnt = p - k;
                        chk("R6 pwm level", int'(pwm_out),
                            (m == 1) ? int'(cnt <= c) : int'(cnt < c));
                        chk("R4 aux level", int'(aux_out), int'(cnt == 0));
                        chk("R5 tc pulse", int'(tc_pulse), int'(k == p));
                        hi += int'(pwm_out);
                        @(negedge clk);
                    end
                    chk("R3 reload aux", int'(aux_out), int'(p == 0));
                    chk("R5 no repeat", int'(tc_pulse), 0);
                    lim = (m == 1) ? c + 1 : c;
                    chk("R6 duty", hi, (lim < p + 1) ? lim : p + 1);
                end
            end
        end

        // R7 R8 changes in mid period
        wr(AD_CTL, 8'h00);
        wr(AD_PER, 8'd7);
        wr(AD_CMP, 8'd2);
        wr(AD_CTL, 8'h01);
        chk("R7 start pwm", int'(pwm_out), 0);
        wr(AD_CMP, 8'd5);
        wr(AD_PER, 8'd3);
        for (int k = 0; k < 6; k++) begin
            chk("R7 old compare", int'(pwm_out), int'((5 - k) < 2));
            chk("R8 old period", int'(aux_out), int'(k == 5));
            @(negedge clk);
        end
        for (int k = 0; k < 8; k++) begin
            chk("R7 new compare", int'(pwm_out), 1);
            chk("R8 new period", int'(aux_out), int'((k % 4) == 3));
            @(negedge clk);
        end

        // R10 enabled count read, R7 held write
        rd(AD_CNT, rv); chk("R10 reads zero", int'(rv), 0);
        rd(AD_CMP, rv); chk("R10 no copy", int'(rv), 5);
        wr(AD_CMP, 8'd1);
        rd(AD_CMP, rv); chk("R7 held", int'(rv), 5);
        repeat (5) @(negedge clk);
        rd(AD_CMP, rv); chk("R7 after reload", int'(rv), 1);

        // R9 R12 capture after stopping
        wr(AD_CTL, 8'h00);
        wr(AD_PER, 8'd9);
        wr(AD_CMP, 8'd0);
        wr(AD_CTL, 8'h01);
        repeat (3) @(negedge clk);
        wr(AD_CTL, 8'h00);
        chk("R6 disabled pwm", int'(pwm_out), 0);
        chk("R12 disabled aux", int'(aux_out), 0);
        rd(AD_CNT, rv); chk("R9 reads zero", int'(rv), 0);
        rd(AD_CMP, rv); chk("R9 captured", int'(rv), 5);
        repeat (4) @(negedge clk);
        rd(AD_CNT, rv);
        rd(AD_CMP, rv); chk("R12 count held", int'(rv), 5);
        rd(AD_CMP, rv); chk("R13 rdata holds", int'(rdata), 5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule